// File: doc/BRIEF.md
# Clock Output Gating and Reset Sequencer

This block is the control core of a multi-output clock buffer. It turns a global enable, per-output request lines and single-ended output enables, each available both as a pin and as a software register bit, into effective enables for every output. Differential outputs are stopped and restarted cleanly: each enable is resampled on the falling edge of the reference clock, so a stopped output parks low and never emits a shortened pulse. Outputs marked as free running ignore the global enable and their request line, and only power-down stops them.

The block also drives an active-low reset status output for downstream logic. The output is low after power-up and whenever power-down is asserted. It falls on loss of the global enable only once every gated differential output has actually parked low. It rises again only after the release conditions have held for a programmable number of reference cycles; the default corresponds to 100 ms at 100 MHz. A register bit forces the output low without touching any clock.

Top module: `clk_gate_rst_seq`

## Requirements
- R1: The effective global enable is `gen_pin | gen_bit`, where `gen_bit` is bit 0 of the control register (select 0, reset value 0). Software can therefore run the outputs and release reset while the pin is low.
- R2: The request for differential output i is active when `req_n_pin[i]` is 0 or bit i of the request register (select 1) is 1. Single-ended output j is enabled when `oe_pin[j]` is 1 or bit j of the OE register (select 2) is 1. Power-down clears every single-ended enable. All register reset values are 0.
- R3: While the effective global enable is low, every differential output that is not free running is disabled, whatever its request state.
- R4: A differential output whose bit is set in the free-running register (select 3, reset value 0) stays enabled whatever the global enable and its request. Power-down disables every output, free running or not.
- R5: Enables change only on the falling edge of `clk`. Each gated clock is `clk` ANDed with its enable, so it is low during every low phase and, while enabled, high during every high phase.
- R6: `rst_out_n` is 0 during and after reset, and it is 0 on the rising edge that follows any cycle in which `pd` was high.
- R7: With power-down low and the control bit at 1, a loss of the global enable makes `rst_out_n` fall only on a rising edge at which every non-free-running differential enable is already 0. Until that edge it keeps its previous value.
- R8: `rst_out_n` rises after the REL_CYCLES-th consecutive rising edge at which `pd` = 0, the global enable = 1 and the control bit = 1. Any edge without those conditions restarts the count from zero.
- R9: Bit 1 of the control register resets to 1. Writing it to 0 drives `rst_out_n` low on the next rising edge and leaves every clock enable unchanged. Writing it back to 1 starts a fresh release count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd | input | 1 | Power-down, active high |
| gen_pin | input | 1 | Global enable pin for differential outputs |
| req_n_pin | input | N_DIFF | Per-output request pins, active low |
| oe_pin | input | N_SE | Single-ended output enable pins |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 request, 2 OE, 3 free running |
| wr_data | input | REG_W | Register write data |
| diff_en | output | N_DIFF | Differential output enables, updated on the falling edge |
| diff_clk | output | N_DIFF | Gated differential clocks |
| se_en | output | N_SE | Single-ended output enables |
| se_clk | output | N_SE | Gated single-ended clocks |
| rst_out_n | output | 1 | Reset status output, active low |

## Verification
Two functions can act on the same rising edge. The first is the completion of the release count. The second is the loss of the global enable, which starts the stop-and-fall path. The bench raises the release conditions and removes the global enable pin one cycle before the terminal edge. At that edge the output must stay low, and after re-enable a full fresh count must be required. Enable gating is swept over every combination of pins, override bits and several free-running patterns. The expected enable of each output is computed arithmetically from the stated OR rules.

// File: rtl/clk_gate_pkg.sv
// Shared definitions for the clock gating and reset sequencer.
package clk_gate_pkg;

    // Register select codes on the write port.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_REQ  = 2'd1,
        SEL_OE   = 2'd2,
        SEL_FREE = 2'd3
    } reg_sel_e;

    // Bit positions inside the control register.
    localparam int CTRL_GEN_BIT = 0;
    localparam int CTRL_RST_BIT = 1;

endpackage

// File: rtl/cg_ctl_regs.sv
// Override register file and effective-enable combiner.
// Holds the software override bits, the free-running flags and the
// reset-control bit. Every pin enable is ORed with its register bit.
// Assumes REG_W covers N_DIFF, N_SE and the two control bits.
module cg_ctl_regs
    import clk_gate_pkg::*;
#(
    parameter int N_DIFF = 4,
    parameter int N_SE   = 2,
    parameter int REG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              gen_pin,
    input  logic [N_DIFF-1:0] req_n_pin,
    input  logic [N_SE-1:0]   oe_pin,
    output logic              gen_eff,
    output logic [N_DIFF-1:0] req_eff,
    output logic [N_SE-1:0]   oe_eff,
    output logic [N_DIFF-1:0] fr_q,
    output logic              rst_bit
);

    logic              gen_bit;
    logic [N_DIFF-1:0] req_bits;
    logic [N_SE-1:0]   oe_bits;

    // Register writes; the reset-control bit comes out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_bit  <= 1'b0;
            rst_bit  <= 1'b1;
            req_bits <= '0;
            oe_bits  <= '0;
            fr_q     <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    gen_bit <= wr_data[CTRL_GEN_BIT];
                    rst_bit <= wr_data[CTRL_RST_BIT];
                end
                SEL_REQ:  req_bits <= wr_data[N_DIFF-1:0];
                SEL_OE:   oe_bits  <= wr_data[N_SE-1:0];
                SEL_FREE: fr_q     <= wr_data[N_DIFF-1:0];
                default:  ;
            endcase
        end
    end

    // Pin OR register for each enable.
    always_comb begin
        gen_eff = gen_pin | gen_bit;
        req_eff = ~req_n_pin | req_bits;
        oe_eff  = oe_pin | oe_bits;
    end

endmodule

// File: rtl/cg_stop_cell.sv
// Glitch-free stop cell for one clock output.
// The enable is sampled on the falling edge, so it only changes while
// the clock is low; the gated clock therefore parks low with no runt.
module cg_stop_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic en_q,
    output logic gclk
);

    // Falling-edge enable capture with synchronous reset.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= want;
    end

    // AND gate: high only in high phases while enabled.
    assign gclk = clk & en_q;

endmodule

// File: rtl/cg_rst_timer.sv
// Reset status sequencer.
// Drives the active-low reset output from power-down, the effective
// global enable, the reset-control bit and the stopped state of the
// gated outputs. Release waits REL_CYCLES qualified rising edges.
// Assumes REL_CYCLES >= 1.
module cg_rst_timer #(
    parameter int REL_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic gen_eff,
    input  logic rst_bit,
    input  logic all_stopped,
    output logic rst_out_n
);

    localparam int           CW       = $clog2(REL_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(REL_CYCLES);
    localparam logic [CW-1:0] CNT_END = CW'(REL_CYCLES - 1);

    logic          rel_ok;
    logic [CW-1:0] cnt;

    // Release conditions that must hold continuously.
    assign rel_ok = !pd && gen_eff && rst_bit;

    // Saturating release counter, cleared whenever conditions drop.
    always_ff @(posedge clk) begin
        if (!rst_n || !rel_ok)  cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
    end

    // Reset output state: forced low, released, or dropped once stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                rst_out_n <= 1'b0;
        else if (pd || !rst_bit)   rst_out_n <= 1'b0;
        else if (gen_eff)          rst_out_n <= rst_out_n | (cnt >= CNT_END);
        else if (all_stopped)      rst_out_n <= 1'b0;
    end

endmodule

// File: rtl/clk_gate_rst_seq.sv
// Clock output gating and reset sequencer, top level.
// Combines pin and register enables, gates each differential and
// single-ended output through a falling-edge stop cell, and sequences
// the reset status output. Assumes all inputs are synchronous to clk.
module clk_gate_rst_seq #(
    parameter int N_DIFF     = 4,
    parameter int N_SE       = 2,
    parameter int REL_CYCLES = 10_000_000,
    localparam int W_MAX     = (N_DIFF > N_SE) ? N_DIFF : N_SE,
    localparam int REG_W     = (W_MAX > 2) ? W_MAX : 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd,
    input  logic              gen_pin,
    input  logic [N_DIFF-1:0] req_n_pin,
    input  logic [N_SE-1:0]   oe_pin,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [N_DIFF-1:0] diff_en,
    output logic [N_DIFF-1:0] diff_clk,
    output logic [N_SE-1:0]   se_en,
    output logic [N_SE-1:0]   se_clk,
    output logic              rst_out_n
);

    logic              gen_eff;
    logic              rst_bit;
    logic [N_DIFF-1:0] req_eff;
    logic [N_DIFF-1:0] fr_q;
    logic [N_SE-1:0]   oe_eff;
    logic [N_DIFF-1:0] diff_want;
    logic [N_SE-1:0]   se_want;
    logic              all_stopped;

    cg_ctl_regs #(
        .N_DIFF (N_DIFF),
        .N_SE   (N_SE),
        .REG_W  (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .gen_pin   (gen_pin),
        .req_n_pin (req_n_pin),
        .oe_pin    (oe_pin),
        .gen_eff   (gen_eff),
        .req_eff   (req_eff),
        .oe_eff    (oe_eff),
        .fr_q      (fr_q),
        .rst_bit   (rst_bit)
    );

    // Desired enables: power-down wins, free running bypasses gating.
    always_comb begin
        diff_want = {N_DIFF{~pd}} & (fr_q | ({N_DIFF{gen_eff}} & req_eff));
        se_want   = {N_SE{~pd}} & oe_eff;
    end

    // One stop cell per differential output.
    for (genvar i = 0; i < N_DIFF; i++) begin : g_diff
        cg_stop_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (diff_want[i]),
            .en_q  (diff_en[i]),
            .gclk  (diff_clk[i])
        );
    end

    // One stop cell per single-ended output.
    for (genvar j = 0; j < N_SE; j++) begin : g_se
        cg_stop_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (se_want[j]),
            .en_q  (se_en[j]),
            .gclk  (se_clk[j])
        );
    end

    // Every gated (non-free-running) differential output is parked low.
    assign all_stopped = &(~diff_en | fr_q);

    cg_rst_timer #(
        .REL_CYCLES (REL_CYCLES)
    ) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd          (pd),
        .gen_eff     (gen_eff),
        .rst_bit     (rst_bit),
        .all_stopped (all_stopped),
        .rst_out_n   (rst_out_n)
    );

endmodule

// File: rtl/clk_gate_rst_seq_chk.sv
// Property checker for the gating and reset sequencer, bound to the top.
// Inputs are sampled at the rising edge; enables seen there were
// captured at the preceding falling edge from the same input values.
module clk_gate_rst_seq_chk #(
    parameter int N_DIFF = 4,
    parameter int N_SE   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd,
    input logic              gen_eff,
    input logic              rst_bit,
    input logic [N_DIFF-1:0] fr_q,
    input logic [N_DIFF-1:0] diff_en,
    input logic [N_SE-1:0]   se_en,
    input logic              rst_out_n
);

    // R3: global enable low leaves only free-running outputs enabled.
    p_gen_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && !gen_eff) |-> ((diff_en & ~fr_q) == '0));

    // R4: free-running outputs stay enabled outside power-down.
    p_free_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pd |-> ((diff_en & fr_q) == fr_q));

    // R4: power-down clears every enable.
    p_pd_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> (diff_en == '0 && se_en == '0));

    // R6: power-down forces reset low on the following edge.
    p_pd_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> !rst_out_n);

    // R7: the stop path only lowers reset once gated outputs are parked.
    p_fall_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out_n) && $past(!pd && rst_bit))
            |-> $past((diff_en & ~fr_q) == '0));

    // R8: reset rises only out of a qualified edge.
    p_rise_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(!pd && gen_eff && rst_bit));

    // R9: a cleared control bit forces reset low.
    p_bit_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_bit |=> !rst_out_n);

endmodule

bind clk_gate_rst_seq clk_gate_rst_seq_chk #(
    .N_DIFF (N_DIFF),
    .N_SE   (N_SE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd        (pd),
    .gen_eff   (gen_eff),
    .rst_bit   (rst_bit),
    .fr_q      (fr_q),
    .diff_en   (diff_en),
    .se_en     (se_en),
    .rst_out_n (rst_out_n)
);

// File: tb/clk_gate_rst_seq_test.sv
// Self-checking bench: directed reset sequencing plus sweeps of the
// enable combining over pins, override bits and free-running patterns.
module clk_gate_rst_seq_test;

    localparam int ND  = 4;
    localparam int NS  = 2;
    localparam int REL = 20;

    logic          clk = 1'b0;
    logic          rst_n, pd, gen_pin, wr_en;
    logic [ND-1:0] req_n_pin;
    logic [NS-1:0] oe_pin;
    logic [1:0]    wr_sel;
    logic [3:0]    wr_data;
    logic [ND-1:0] diff_en, diff_clk;
    logic [NS-1:0] se_en, se_clk;
    logic          rst_out_n;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    clk_gate_rst_seq #(.N_DIFF(ND), .N_SE(NS), .REL_CYCLES(REL)) uut (
        .clk(clk), .rst_n(rst_n), .pd(pd), .gen_pin(gen_pin),
        .req_n_pin(req_n_pin), .oe_pin(oe_pin), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .diff_en(diff_en),
        .diff_clk(diff_clk), .se_en(se_en), .se_clk(se_clk),
        .rst_out_n(rst_out_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Expect rst_out_n to rise exactly after the REL-th qualified edge.
    task automatic release_count(input string tag);
        for (int k = 1; k <= REL; k++) begin
            @(posedge clk); #1;
            chk(tag, rst_out_n, (k >= REL) ? 1 : 0);
        end
    endtask

    function automatic logic [ND-1:0] exp_diff(input logic p, input logic gp,
            input logic gb, input logic [ND-1:0] rn, input logic [ND-1:0] rb,
            input logic [ND-1:0] fr);
        logic g;
        g = gp | gb;
        return p ? '0 : (fr | ({ND{g}} & (~rn | rb)));
    endfunction

    localparam logic [ND-1:0] FRP [4] = '{4'h0, 4'h5, 4'hA, 4'hF};

    initial begin
        rst_n = 1'b0; pd = 1'b1; gen_pin = 1'b0; req_n_pin = '1;
        oe_pin = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R6: reset state
        chk("R6 reset rst_out_n", rst_out_n, 0);
        chk("R5 reset diff_en", diff_en, 0);
        chk("R2 reset se_en", se_en, 0);

        // R8/R9: release from power-up with default control bit
        @(posedge clk); #1;
        pd = 1'b0; gen_pin = 1'b1;
        release_count("R8 first release");

        // R6: power-down forces reset low
        pd = 1'b1;
        @(posedge clk); #1;
        chk("R6 pd low", rst_out_n, 0);
        pd = 1'b0;

        // R8: collision of terminal count with loss of global enable
        for (int k = 1; k < REL; k++) begin
            @(posedge clk); #1;
            chk("R8 partial count", rst_out_n, 0);
        end
        gen_pin = 1'b0;
        @(posedge clk); #1;
        chk("R8 terminal edge without enable", rst_out_n, 0);
        gen_pin = 1'b1;
        release_count("R8 restarted count");

        // R7: outputs running, then global enable removed
        req_n_pin = '0;
        @(negedge clk); #1;
        chk("R3 all requested", diff_en, 4'hF);
        @(posedge clk); #1;
        gen_pin = 1'b0;
        @(negedge clk); #1;
        chk("R3 stopped on gen loss", diff_en, 0);
        chk("R7 high until stopped seen", rst_out_n, 1);
        @(posedge clk); #1;
        chk("R7 fall after parked", rst_out_n, 0);
        gen_pin = 1'b1;
        release_count("R8 release after stop");

        // R4: free-running outputs survive the global stop
        wr(2'd3, 4'h3);
        gen_pin = 1'b0;
        @(negedge clk); #1;
        chk("R4 free running kept", diff_en, 4'h3);
        chk("R5 low phase parked", diff_clk, 0);
        @(posedge clk); #1;
        chk("R7 fall with free running", rst_out_n, 0);
        chk("R5 high phase toggles", diff_clk, 4'h3);

        // R1: register override re-enables with pin low
        wr(2'd0, 4'h3);
        @(negedge clk); #1;
        chk("R1 override enables", diff_en, 4'hF);
        release_count("R1 override release");

        // R9: clearing the control bit lowers reset, clocks untouched
        wr(2'd0, 4'h1);
        chk("R9 not yet low", rst_out_n, 1);
        @(posedge clk); #1;
        chk("R9 forced low", rst_out_n, 0);
        @(negedge clk); #1;
        chk("R9 clocks unchanged", diff_en, 4'hF);
        wr(2'd0, 4'h3);
        release_count("R9 release after bit set");

        // R4: power-down stops free-running outputs too
        pd = 1'b1;
        @(negedge clk); #1;
        chk("R4 pd stops all", diff_en, 0);
        @(posedge clk); #1;
        chk("R6 pd reset low", rst_out_n, 0);
        pd = 1'b0;

        // R1/R2/R3/R4/R5: sweep of differential enable combining
        for (int f = 0; f < 4; f++) begin
            for (int rb = 0; rb < 16; rb++) begin
                for (int gb = 0; gb < 2; gb++) begin
                    wr(2'd3, FRP[f]);
                    wr(2'd1, 4'(rb));
                    wr(2'd0, {2'b00, 1'b1, 1'(gb)});
                    for (int p = 0; p < 64; p++) begin
                        pd = p[5]; gen_pin = p[4]; req_n_pin = p[3:0];
                        @(negedge clk); #1;
                        chk("R3 sweep diff_en", diff_en,
                            exp_diff(p[5], p[4], 1'(gb), p[3:0], 4'(rb), FRP[f]));
                        chk("R5 sweep low phase", diff_clk, 0);
                        @(posedge clk); #1;
                        chk("R5 sweep high phase", diff_clk, diff_en);
                    end
                end
            end
        end

        // R2: single-ended enable sweep
        for (int ob = 0; ob < 4; ob++) begin
            wr(2'd2, 4'(ob));
            for (int p = 0; p < 8; p++) begin
                pd = p[2]; oe_pin = p[1:0];
                @(negedge clk); #1;
                chk("R2 se_en", se_en, p[2] ? 0 : int'(p[1:0] | 2'(ob)));
                @(posedge clk); #1;
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule